// File: doc/BRIEF.md
# Partitioned Control-Word Store with Incremental Update

This block holds one control word for each partition of a scan response. The response of a test vector is split into partitions, and each partition is compacted into its own signature. Between vectors the tester sends update records. Each record carries a partition index and a new control word. The block writes the word into the addressed slot only. Every other slot keeps the word it held for the previous vector, so only the partitions whose canceling bits change have to be sent again.

A single ready pulse from the tester starts compaction of the vector. The block then presents the stored words one partition at a time on its control output. It moves to the next partition on each signature-done pulse. After the last partition it returns to the loading state and waits for new records or the next ready pulse.

An update that arrives while compaction is running is refused and raises a sticky error flag. An update that names a partition which does not exist is treated the same way.

The sequencer has two states and four transitions:
- `ST_LOAD` accepts update records.
- `ST_RUN` presents control words partition by partition.
- `ST_LOAD` goes to `ST_RUN` on a ready pulse.
- `ST_RUN` stays in `ST_RUN` and advances the partition on a signature-done pulse for any partition except the last.
- `ST_RUN` goes back to `ST_LOAD` on a signature-done pulse for the last partition.
- Each state holds when neither of its events occurs.

Top module: `xcs_ctrl_store`

## Requirements
- R1: After reset, every slot holds zero, the block is in `ST_LOAD` (`ctl_active` = 0), `ctl_part` = 0 and `upd_err` = 0.
- R2: In `ST_LOAD`, an update with `upd_valid` = 1 and `upd_idx` < NPART writes `upd_data` into slot `upd_idx` at the clock edge and leaves every other slot unchanged.
- R3: A `vec_ready` pulse in `ST_LOAD` puts the block in `ST_RUN` at the next edge, with `ctl_active` = 1, `ctl_part` = 0 and `ctl_word` equal to slot 0.
- R4: In `ST_RUN`, a `sig_done` pulse on partition p < NPART-1 sets `ctl_part` to p+1, and `ctl_word` then shows slot p+1.
- R5: A `sig_done` pulse on partition NPART-1 returns the block to `ST_LOAD` (`ctl_active` = 0).
- R6: An update in `ST_RUN` does not change any slot, and it sets `upd_err`. `upd_err` then stays 1 until reset.
- R7: An update with `upd_idx` >= NPART does not change any slot, and it sets `upd_err`.
- R8: A slot that is not addressed by an update keeps its word across any number of vectors.
- R9: A ready pulse that arrives before any update is legal. Compaction then runs over all-zero words.
- R10: `vec_ready` has no effect in `ST_RUN`, and `sig_done` has no effect in `ST_LOAD`.
- R11: `ctl_word` is zero whenever `ctl_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | Update record present |
| upd_idx | input | IDX_W | Partition index of the update |
| upd_data | input | CW_W | Control word to store |
| vec_ready | input | 1 | Tester pulse: updates finished, start compaction |
| sig_done | input | 1 | Pulse: current partition's signature complete |
| ctl_word | output | CW_W | Control word for the current partition, zero when idle |
| ctl_active | output | 1 | High while compaction runs |
| ctl_part | output | IDX_W | Partition being compacted |
| upd_err | output | 1 | Sticky flag for a refused update |

## Verification
The bench builds the block with its default values: NPART = 6 and CW_W = 16. Six partitions give a 3-bit index that can also name the two partitions that do not exist (6 and 7), so the out-of-range refusal can be driven through the normal port. They also give enough middle partitions to place an update and a ready pulse in the middle of a run. The 16-bit words are wide enough that each slot can carry a distinct pattern, so a write that lands in the wrong slot shows up during the walk over the partitions.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } xcs_state_e;
endpackage

// File: rtl/xcs_slot_store.sv
module xcs_slot_store #(
    parameter int NPART = 6,
    parameter int CW_W  = 16,
    parameter int IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [CW_W-1:0]         wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [CW_W-1:0]         rd_data,
    output logic [NPART*CW_W-1:0]   slots_flat
);
    logic [CW_W-1:0] slot_q [NPART];

    for (genvar g = 0; g < NPART; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
        assign slots_flat[g*CW_W +: CW_W] = slot_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPART; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end
endmodule

// File: rtl/xcs_seq.sv
module xcs_seq
    import xcs_pkg::*;
#(
    parameter int NPART = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_ready,
    input  logic             sig_done,
    output logic             active,
    output logic [IDX_W-1:0] part
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPART - 1);

    xcs_state_e state_q, state_d;
    logic [IDX_W-1:0] part_q, part_d;

    always_comb begin
        state_d = state_q;
        part_d  = part_q;
        unique case (state_q)
            ST_LOAD: begin
                if (vec_ready) begin
                    state_d = ST_RUN;
                    part_d  = '0;
                end
            end
            ST_RUN: begin
                if (sig_done) begin
                    if (part_q == LAST) begin
                        state_d = ST_LOAD;
                        part_d  = '0;
                    end else begin
                        part_d = part_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_LOAD;
                part_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            part_q  <= '0;
        end else begin
            state_q <= state_d;
            part_q  <= part_d;
        end
    end

    always_comb begin
        active = (state_q == ST_RUN);
        part   = part_q;
    end

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && vec_ready) |=> (active && part == '0)); // R3
    AST_PART_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sig_done && part != LAST) |=> (active && part == $past(part) + 1'b1)); // R4
    AST_LAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sig_done && part == LAST) |=> !active); // R5
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !sig_done) |=> (active && $stable(part))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !vec_ready) |=> !active); // R10
endmodule

// File: rtl/xcs_ctrl_store.sv
module xcs_ctrl_store #(
    parameter int NPART = 6,
    parameter int CW_W  = 16,
    localparam int IDX_W = (NPART > 1) ? $clog2(NPART) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [CW_W-1:0]  upd_data,
    input  logic             vec_ready,
    input  logic             sig_done,
    output logic [CW_W-1:0]  ctl_word,
    output logic             ctl_active,
    output logic [IDX_W-1:0] ctl_part,
    output logic             upd_err
);
    logic                  active;
    logic [IDX_W-1:0]      part;
    logic                  idx_ok;
    logic                  wr_en;
    logic                  err_q;
    logic [CW_W-1:0]       rd_data;
    logic [NPART*CW_W-1:0] slots_flat;

    assign idx_ok = (int'(upd_idx) < NPART);
    assign wr_en  = upd_valid && idx_ok && !active;

    xcs_seq #(.NPART(NPART), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_ready (vec_ready),
        .sig_done  (sig_done),
        .active    (active),
        .part      (part)
    );

    xcs_slot_store #(.NPART(NPART), .CW_W(CW_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (upd_idx),
        .wr_data    (upd_data),
        .rd_idx     (part),
        .rd_data    (rd_data),
        .slots_flat (slots_flat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (upd_valid && (active || !idx_ok)) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        ctl_active = active;
        ctl_part   = part;
        ctl_word   = active ? rd_data : '0;
        upd_err    = err_q;
    end

    AST_NO_WRITE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(slots_flat)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_err |=> upd_err); // R6
    AST_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !idx_ok) |=> (upd_err && $stable(slots_flat))); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_active |-> (ctl_word == '0)); // R11
endmodule

// File: tb/sim_xcs_ctrl_store.sv
`timescale 1ns/1ps
module sim_xcs_ctrl_store;
    localparam int NPART = 6;
    localparam int CW_W  = 16;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_idx = '0;
    logic [CW_W-1:0] upd_data = '0;
    logic vec_ready = 1'b0;
    logic sig_done = 1'b0;
    logic [CW_W-1:0] ctl_word;
    logic ctl_active;
    logic [IDX_W-1:0] ctl_part;
    logic upd_err;

    int checks = 0;
    int errors = 0;
    logic [CW_W-1:0] exp_slot [NPART];

    always #2.5 clk = ~clk;

    xcs_ctrl_store #(.NPART(NPART), .CW_W(CW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_data(upd_data), .vec_ready(vec_ready), .sig_done(sig_done),
        .ctl_word(ctl_word), .ctl_active(ctl_active), .ctl_part(ctl_part),
        .upd_err(upd_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NPART; i++) exp_slot[i] = '0;
    endtask

    task automatic send_upd(input int idx, input logic [CW_W-1:0] data);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_idx = IDX_W'(idx);
        upd_data = data;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        vec_ready = 1'b1;
        @(negedge clk);
        vec_ready = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        sig_done = 1'b1;
        @(negedge clk);
        sig_done = 1'b0;
    endtask

    task automatic walk_vector(input string req);
        pulse_ready();
        check({req, " R3 active"}, 32'(ctl_active), 32'd1);
        for (int p = 0; p < NPART; p++) begin
            check({req, " R4 part"}, 32'(ctl_part), 32'(p));
            check({req, " R4 word"}, 32'(ctl_word), 32'(exp_slot[p]));
            pulse_done();
        end
        check({req, " R5 idle"}, 32'(ctl_active), 32'd0);
        check({req, " R11 zero"}, 32'(ctl_word), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 active", 32'(ctl_active), 32'd0);
        check("R1 part", 32'(ctl_part), 32'd0);
        check("R1 err", 32'(upd_err), 32'd0);
        check("R11 word idle", 32'(ctl_word), 32'd0);
    endtask

    task automatic t_ready_first();
        walk_vector("R9 ready-first R1 zero slots");
    endtask

    task automatic t_full_load();
        for (int i = 0; i < NPART; i++) begin
            exp_slot[i] = CW_W'(16'hA100 + i * 16'h0111);
            send_upd(i, exp_slot[i]);
        end
        check("R2 no err", 32'(upd_err), 32'd0);
        walk_vector("R2 full load");
    endtask

    task automatic t_partial();
        exp_slot[4] = 16'h5A5A;
        send_upd(4, exp_slot[4]);
        walk_vector("R8 partial update");
        exp_slot[0] = 16'hFFFF;
        send_upd(0, exp_slot[0]);
        walk_vector("R8 second vector");
    endtask

    task automatic t_bad_index();
        send_upd(7, 16'hDEAD);
        check("R7 err", 32'(upd_err), 32'd1);
        send_upd(6, 16'hBEEF);
        walk_vector("R7 slots untouched");
    endtask

    task automatic t_run_conflicts();
        pulse_ready();
        pulse_done();
        pulse_done();
        check("R4 at part 2", 32'(ctl_part), 32'd2);
        send_upd(3, 16'h1234);
        check("R6 err set", 32'(upd_err), 32'd1);
        pulse_ready();
        check("R10 ready in run", 32'(ctl_part), 32'd2);
        check("R10 still active", 32'(ctl_active), 32'd1);
        for (int p = 2; p < NPART; p++) begin
            check("R6 word kept", 32'(ctl_word), 32'(exp_slot[p]));
            pulse_done();
        end
        check("R5 idle", 32'(ctl_active), 32'd0);
        pulse_done();
        check("R10 done in load", 32'(ctl_active), 32'd0);
        check("R6 sticky", 32'(upd_err), 32'd1);
        walk_vector("R6 after refused write");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_ready_first();
        t_full_load();
        t_partial();
        t_bad_index();
        do_reset();
        t_reset();
        exp_slot[1] = 16'h0F0F;
        send_upd(1, exp_slot[1]);
        exp_slot[3] = 16'h7777;
        send_upd(3, exp_slot[3]);
        t_run_conflicts();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule